// File: doc/BRIEF.md
# Sector Erase Batch Collector

This block sits between a flash command decoder and the erase engine. It gathers sector-erase requests for several sectors into one batch, so that they are all erased at the same time. Once the decoder has recognised a complete sector-erase command, including its unlock prefix, it pulses `firstCmd`. The block then records the sector selected by the upper address bits and opens an acceptance window.

While the window is open, a plain write of the erase code (30h) with another sector address adds that sector to the batch. No unlock cycles are needed for these writes, and each accepted code starts the window again from zero. Any other data written while the window is open abandons the batch.

When the window runs out with no further writes, the block hands its sector mask to the erase engine with a single start strobe. It then holds the mask until the engine reports that it is done. A status bit reads 0 while the window is counting and 1 once the erase is under way.

Top module: `sector_erase_batcher`

## Requirements
- R1: After reset, `sectorMask` is 0, `eraseStart` is 0 and `timeoutFlag` is 0.
- R2: A `firstCmd` pulse while idle sets the mask bit whose index is `wrAddr[ADDR_W-1 -: 3]` (bit n means sector n). It also opens the window, and `timeoutFlag` stays 0.
- R3: A write (`wrEn`) with `wrData` equal to 30h while the window is open sets the mask bit of its sector. Bits already set are kept.
- R4: Every accepted 30h write restarts the window. `eraseStart` goes high on the WIN_CYCLES-th rising edge after the edge that took the last accepted command (either `firstCmd` or a 30h write), provided no write occurs in between.
- R5: On expiry, `eraseStart` is high for exactly one cycle, with `sectorMask` holding the full batch. `timeoutFlag` rises in that same cycle.
- R6: A write whose data is not 30h while the window is open clears the mask and returns the block to idle. No start strobe is ever issued for that batch.
- R7: While the erase runs (`timeoutFlag` = 1), writes and `firstCmd` are ignored. The mask keeps its value and no second start strobe is issued.
- R8: `eraseDone` during the erase clears the mask and `timeoutFlag` and returns the block to idle, after which a new `firstCmd` starts a fresh batch. `eraseDone` has no effect while idle or while the window is open.
- R9: A write that arrives in the last cycle of the window takes priority over expiry. A 30h write there extends the batch, and no start strobe is issued in that cycle.
- R10: While idle, writes without `firstCmd` leave the mask at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| firstCmd | input | 1 | Pulse: a complete sector-erase command was decoded |
| wrEn | input | 1 | Write cycle strobe |
| wrData | input | DATA_W | Write data |
| wrAddr | input | ADDR_W | Write address; the top bits select the sector |
| eraseDone | input | 1 | Erase engine has finished |
| sectorMask | output | SECTORS | Sectors selected for erase |
| eraseStart | output | 1 | One-cycle strobe that launches the erase |
| timeoutFlag | output | 1 | 0 while idle or counting; 1 while the erase runs |

## Verification
The bench writes the same sector twice and checks that the mask stays the same. A design that toggled bits instead of setting them would clear that sector. It places a 30h write in the final window cycle; a design that let expiry win would start the erase early, with that sector missing from the mask. It cancels a batch with foreign data and then waits out a full window, which exposes a design that still fires the start strobe. It also sends writes and `firstCmd` during the erase, which catches a design that reopens the window or lets a second start strobe through.

// File: rtl/seb_pkg.sv
package seb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } sebState_t;

  // Strobes sent from the control unit to the datapath
  typedef struct packed {
    logic addSector;    // OR the addressed sector into the mask
    logic clearMask;    // drop every sector
    logic restartTimer; // window counter back to zero
    logic countEn;      // window counter advances
  } sebCtl_t;

endpackage

// File: rtl/seb_datapath.sv
module seb_datapath
  import seb_pkg::*;
#(
  parameter int SECTORS    = 8,
  parameter int ADDR_W     = 16,
  parameter int WIN_CYCLES = 5000
) (
  input  logic               clk,
  input  logic               rstN,
  input  sebCtl_t            ctl,
  input  logic [ADDR_W-1:0]  wrAddr,
  output logic [SECTORS-1:0] mask,
  output logic               winExpired
);
  localparam int SEL_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;
  localparam int CNT_W = $clog2(WIN_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] winCnt;

  assign sel = wrAddr[ADDR_W-1 -: SEL_W];

  // one flop per sector bit
  for (genvar g = 0; g < SECTORS; g++) begin : g_maskBit
    always_ff @(posedge clk) begin
      if (!rstN)                                     mask[g] <= 1'b0;
      else if (ctl.clearMask)                        mask[g] <= 1'b0;
      else if (ctl.addSector && sel == SEL_W'(g))    mask[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                winCnt <= '0;
    else if (ctl.restartTimer) winCnt <= '0;
    else if (ctl.countEn)      winCnt <= winCnt + 1'b1;
  end

  assign winExpired = (winCnt == LAST);

endmodule

// File: rtl/seb_control.sv
module seb_control
  import seb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] ERASE_CODE = 8'h30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              firstCmd,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              eraseDone,
  input  logic              winExpired,
  output sebCtl_t           ctl,
  output logic              eraseStart,
  output logic              erasing
);
  sebState_t state, stateNext;
  logic      fire;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    fire      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (firstCmd) begin
          ctl.addSector    = 1'b1;
          ctl.restartTimer = 1'b1;
          stateNext        = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (wrEn) begin
          if (wrData == ERASE_CODE) begin
            ctl.addSector    = 1'b1;
            ctl.restartTimer = 1'b1;
          end else begin
            ctl.clearMask = 1'b1;
            stateNext     = ST_IDLE;
          end
        end else if (winExpired) begin
          fire      = 1'b1;
          stateNext = ST_ERASE;
        end else begin
          ctl.countEn = 1'b1;
        end
      end
      ST_ERASE: begin
        if (eraseDone) begin
          ctl.clearMask = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      eraseStart <= 1'b0;
    end else begin
      state      <= stateNext;
      eraseStart <= fire;
    end
  end

  assign erasing = (state == ST_ERASE);

endmodule

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher
  import seb_pkg::*;
#(
  parameter int SECTORS    = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int WIN_CYCLES = 5000,
  parameter logic [DATA_W-1:0] ERASE_CODE = 8'h30
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               firstCmd,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic               eraseDone,
  output logic [SECTORS-1:0] sectorMask,
  output logic               eraseStart,
  output logic               timeoutFlag
);
  sebCtl_t ctl;
  logic    winExpired;

  seb_control #(.DATA_W(DATA_W), .ERASE_CODE(ERASE_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .firstCmd(firstCmd), .wrEn(wrEn),
    .wrData(wrData), .eraseDone(eraseDone), .winExpired(winExpired),
    .ctl(ctl), .eraseStart(eraseStart), .erasing(timeoutFlag)
  );

  seb_datapath #(.SECTORS(SECTORS), .ADDR_W(ADDR_W), .WIN_CYCLES(WIN_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrAddr(wrAddr),
    .mask(sectorMask), .winExpired(winExpired)
  );

endmodule

// File: rtl/sector_erase_batcher_chk.sv
module sector_erase_batcher_chk #(
  parameter int SECTORS = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter logic [DATA_W-1:0] ERASE_CODE = 8'h30
) (
  input logic               clk,
  input logic               rstN,
  input logic               firstCmd,
  input logic               wrEn,
  input logic [DATA_W-1:0]  wrData,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic               eraseDone,
  input logic [SECTORS-1:0] sectorMask,
  input logic               eraseStart,
  input logic               timeoutFlag
);
  localparam int SEL_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic [SECTORS-1:0] selBit;
  logic inWindow, isIdle;
  assign selBit   = SECTORS'(1) << wrAddr[ADDR_W-1 -: SEL_W];
  assign inWindow = !timeoutFlag && (sectorMask != '0);
  assign isIdle   = !timeoutFlag && (sectorMask == '0);

  // R5
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);
  // R5
  start_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> timeoutFlag);
  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> eraseStart);
  // R3
  add_sector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWindow && wrEn && wrData == ERASE_CODE)
      |=> ((sectorMask & $past(selBit)) == $past(selBit)) && !eraseStart);
  // R6
  cancel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inWindow && wrEn && wrData != ERASE_CODE)
      |=> (sectorMask == '0) && !eraseStart && !timeoutFlag);
  // R7
  hold_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !eraseDone) |=> $stable(sectorMask) && timeoutFlag);
  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && eraseDone) |=> (sectorMask == '0) && !timeoutFlag);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && !firstCmd) |=> (sectorMask == '0) && !timeoutFlag);

endmodule

bind sector_erase_batcher sector_erase_batcher_chk #(
  .SECTORS(SECTORS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERASE_CODE(ERASE_CODE)
) u_chk (.*);

// File: tb/sector_erase_batcher_bench.sv
module sector_erase_batcher_bench;
  localparam int WIN = 4;

  logic       clk = 1'b0;
  logic       rstN;
  logic       firstCmd, wrEn, eraseDone;
  logic [7:0] wrData;
  logic [15:0] wrAddr;
  logic [7:0] sectorMask;
  logic       eraseStart, timeoutFlag;

  int checks = 0;
  int errors = 0;

  sector_erase_batcher #(.WIN_CYCLES(WIN)) u_sector_erase_batcher (
    .clk(clk), .rstN(rstN), .firstCmd(firstCmd), .wrEn(wrEn), .wrData(wrData),
    .wrAddr(wrAddr), .eraseDone(eraseDone), .sectorMask(sectorMask),
    .eraseStart(eraseStart), .timeoutFlag(timeoutFlag)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic       fc;
    logic       we;
    logic [7:0] data;
    logic [2:0] sec;
    logic       done;
    logic [7:0] expMask;
    logic       expStart;
    logic       expFlag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 8'h00, 3'd2, 1'b0, 8'h04, 1'b0, 1'b0}, // R2 first command
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 8'h04, 1'b0, 1'b0}, // R8 done ignored in window
    '{1'b0, 1'b1, 8'h30, 3'd5, 1'b0, 8'h24, 1'b0, 1'b0}, // R3 add sector 5
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0},
    '{1'b0, 1'b1, 8'h30, 3'd5, 1'b0, 8'h24, 1'b0, 1'b0}, // R3 repeat keeps bit, R4 restart
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h24, 1'b1, 1'b1}, // R4 R5 expiry
    '{1'b0, 1'b1, 8'h30, 3'd0, 1'b0, 8'h24, 1'b0, 1'b1}, // R7 write ignored
    '{1'b1, 1'b0, 8'h00, 3'd7, 1'b0, 8'h24, 1'b0, 1'b1}, // R7 first cmd ignored
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b1, 8'h00, 1'b0, 1'b0}, // R8 done
    '{1'b0, 1'b1, 8'h30, 3'd1, 1'b0, 8'h00, 1'b0, 1'b0}, // R10 idle write
    '{1'b1, 1'b0, 8'h00, 3'd0, 1'b0, 8'h01, 1'b0, 1'b0}, // R8 new batch
    '{1'b0, 1'b1, 8'h55, 3'd3, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 cancel
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0}, // R6 no start
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0},
    '{1'b0, 1'b0, 8'h00, 3'd0, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic fc, input logic we, input logic [7:0] d,
                       input logic [2:0] sec, input logic dn);
    firstCmd  = fc;
    wrEn      = we;
    wrData    = d;
    wrAddr    = {sec, 13'h0a5};
    eraseDone = dn;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
  endtask

  task automatic expectOut(input string req, input logic [7:0] m,
                           input logic st, input logic fl);
    chk({req, " mask"}, 32'(sectorMask), 32'(m));
    chk({req, " start"}, 32'(eraseStart), 32'(st));
    chk({req, " flag"}, 32'(timeoutFlag), 32'(fl));
  endtask

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(1'b0, 1'b0, 8'h00, 3'd0, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectOut("R1", 8'h00, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].fc, TBL[i].we, TBL[i].data, TBL[i].sec, TBL[i].done);
      step();
      expectOut($sformatf("R2-table step %0d", i), TBL[i].expMask,
                TBL[i].expStart, TBL[i].expFlag);
    end

    // R9: 30h write in last window cycle wins over expiry
    drive(1'b1, 1'b0, 8'h00, 3'd1, 1'b0); step();
    for (int k = 0; k < WIN - 1; k++) step();
    drive(1'b0, 1'b1, 8'h30, 3'd6, 1'b0); step();
    expectOut("R9 late write", 8'h42, 1'b0, 1'b0);
    for (int k = 0; k < WIN - 1; k++) step();
    expectOut("R4 before expiry", 8'h42, 1'b0, 1'b0);
    step();
    expectOut("R5 expiry", 8'h42, 1'b1, 1'b1);
    step();
    expectOut("R5 single strobe", 8'h42, 1'b0, 1'b1);
    drive(1'b0, 1'b0, 8'h00, 3'd0, 1'b1); step();
    expectOut("R8 done", 8'h00, 1'b0, 1'b0);

    // R3: all eight sectors in one batch
    drive(1'b1, 1'b0, 8'h00, 3'd0, 1'b0); step();
    for (int s = 1; s < 8; s++) begin
      drive(1'b0, 1'b1, 8'h30, 3'(s), 1'b0); step();
    end
    expectOut("R3 full mask", 8'hff, 1'b0, 1'b0);
    for (int k = 0; k < WIN; k++) step();
    expectOut("R5 full expiry", 8'hff, 1'b1, 1'b1);
    // R7: long erase, writes ignored, no second strobe
    for (int k = 0; k < 2 * WIN; k++) begin
      drive(1'b0, 1'b1, 8'h30, 3'd0, 1'b0); step();
      expectOut("R7 busy", 8'hff, 1'b0, 1'b1);
    end
    drive(1'b0, 1'b0, 8'h00, 3'd0, 1'b1); step();
    expectOut("R8 done again", 8'h00, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule